// File: doc/BRIEF.md
# External Pin Interrupt Port

This peripheral watches a small group of external pins and raises one interrupt request per pin. Each pin is given one of four sensitivities: level (active low), rising edge, falling edge or both edges. Edge events latch into a flag register that software clears by writing ones. Level-mode flags follow the pin and hold no memory of it. The interrupt output for a line is its flag gated by the line's enable bit. The same pins can also be used as simple general-purpose I/O. A direction register drives the output-enable pins, an output-data register drives the output pins, and a readback register returns the synchronised pin levels.

Software reaches every register through a plain read/write port. A 3-bit select picks the register, writes take effect on the clock edge that sees `reg_we` high, and reads are combinational. Every pin passes through a two-flop synchroniser before any detection. Line 0 exists only as a GPIO and never produces an interrupt.

Top module: `xpin_irq_port`

## Requirements
- R1: Line 0 is reserved. Its flag reads 0 and `irq[0]` stays 0 whatever its sensitivity field, enable bit or pin does.
- R2: The sensitivity register (select 0) holds two bits per line at bits [2i+1:2i]. Code 00 is level, 01 rising edge, 10 falling edge and 11 both edges. An edge flag is set only by the transitions its code names.
- R3: The direction register (select 1) drives `pin_oe`, where a 1 makes the line an output. The output-data register (select 3) drives `pin_out`.
- R4: `irq[i]` equals flag bit i ANDed with bit i of the enable register (select 2). A disabled line never requests, yet its flag still records events.
- R5: Writing the flag register (select 5) clears each edge-mode flag whose written bit is 1. Flags whose written bit is 0 keep their value.
- R6: In an edge mode a flag stays 1 after the pin returns to its old level, until software clears it.
- R7: In level mode a flag reads as the inverse of the synchronised pin. It is not latched, and writing 1 to clear it has no effect.
- R8: If a qualifying edge and a clearing write to the same flag meet on one clock edge, the flag ends at 1.
- R9: The pin readback register (select 4) shows a pin change after two clock edges. An edge flag shows it after three.
- R10: After reset the sensitivity, direction, enable, output-data and flag registers read 0, and every `irq`, `pin_oe` and `pin_out` bit is 0. With the pins held high, this leaves all lines as quiet level-mode inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 3 | Register select |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 2*N | Write data (byte registers use the low N bits) |
| reg_rdata | output | 2*N | Read data of the selected register |
| pin_in | input | N | External pin levels (asynchronous) |
| pin_out | output | N | Output data to the pins |
| pin_oe | output | N | Output enable per pin |
| irq | output | N | Interrupt request per line |

## Verification
The assertions assume that `pin_in` may change at any time, because it passes through the synchroniser. They also assume that a write to the sensitivity register marks the only cycle in which a flag may change by a rule other than set, hold or clear, so the sticky, clear and set-wins properties are suspended on that cycle. The stimulus changes pins and register controls only on falling clock edges. Every pin change is then left to settle for three rising edges before a flag is read, except in the latency and set-wins tests, which count the edges deliberately.

// File: rtl/xpin_pkg.sv
package xpin_pkg;

  typedef enum logic [1:0] {
    SENSE_LEVEL = 2'b00,
    SENSE_RISE  = 2'b01,
    SENSE_FALL  = 2'b10,
    SENSE_BOTH  = 2'b11
  } sense_e;

  localparam logic [2:0] SEL_SENSE = 3'd0;
  localparam logic [2:0] SEL_DIR   = 3'd1;
  localparam logic [2:0] SEL_IEN   = 3'd2;
  localparam logic [2:0] SEL_DOUT  = 3'd3;
  localparam logic [2:0] SEL_PINS  = 3'd4;
  localparam logic [2:0] SEL_FLAG  = 3'd5;

  // Edge qualifier: previous and current synchronised samples against the code.
  function automatic logic edge_hit(input logic [1:0] sense, input logic prev, input logic cur);
    case (sense)
      SENSE_RISE: edge_hit = cur & ~prev;
      SENSE_FALL: edge_hit = prev & ~cur;
      SENSE_BOTH: edge_hit = cur ^ prev;
      default:    edge_hit = 1'b0;
    endcase
  endfunction

  // Next value of a latched flag: a set has priority over a clear.
  function automatic logic flag_next(input logic cur_q, input logic hit, input logic clr);
    if (hit)      flag_next = 1'b1;
    else if (clr) flag_next = 1'b0;
    else          flag_next = cur_q;
  endfunction

endpackage

// File: rtl/xpin_sync.sv
module xpin_sync #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] sync_o,
  output logic [N-1:0] prev_o
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_line
      logic meta_q, sync_q, prev_q;
      // Preset high: idle level of active-low lines, so reset creates no edge.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta_q <= 1'b1;
          sync_q <= 1'b1;
          prev_q <= 1'b1;
        end else begin
          meta_q <= pin_in[g];
          sync_q <= meta_q;
          prev_q <= sync_q;
        end
      end
      assign sync_o[g] = sync_q;
      assign prev_o[g] = prev_q;
    end
  endgenerate
endmodule

// File: rtl/xpin_flags.sv
module xpin_flags
  import xpin_pkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2*N-1:0] sense,
  input  logic [N-1:0]   sync_i,
  input  logic [N-1:0]   prev_i,
  input  logic [N-1:0]   clr_i,
  output logic [N-1:0]   hit_o,
  output logic [N-1:0]   flag_o
);
  localparam logic [N-1:0] LINE_MASK = {{(N-1){1'b1}}, 1'b0};

  logic [N-1:0] hit_raw, flag_raw;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_line
      logic [1:0] code;
      logic       level_mode;
      logic       flag_q;
      assign code       = sense[2*g +: 2];
      assign level_mode = (code == SENSE_LEVEL);
      assign hit_raw[g] = edge_hit(code, prev_i[g], sync_i[g]);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (level_mode) flag_q <= 1'b0;
        else                 flag_q <= flag_next(flag_q, hit_raw[g], clr_i[g]);
      end

      assign flag_raw[g] = level_mode ? ~sync_i[g] : flag_q;
    end
  endgenerate

  assign hit_o  = hit_raw & LINE_MASK;
  assign flag_o = flag_raw & LINE_MASK;
endmodule

// File: rtl/xpin_regs.sv
module xpin_regs
  import xpin_pkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     reg_sel,
  input  logic           reg_we,
  input  logic [2*N-1:0] reg_wdata,
  output logic [2*N-1:0] sense_q,
  output logic [N-1:0]   dir_q,
  output logic [N-1:0]   ien_q,
  output logic [N-1:0]   dout_q,
  output logic [N-1:0]   clr_o,
  output logic           sense_we_o
);
  logic [N-1:0] wbyte;
  assign wbyte      = reg_wdata[N-1:0];
  assign sense_we_o = reg_we && (reg_sel == SEL_SENSE);
  assign clr_o      = (reg_we && (reg_sel == SEL_FLAG)) ? wbyte : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
      dir_q   <= '0;
      ien_q   <= '0;
      dout_q  <= '0;
    end else if (reg_we) begin
      case (reg_sel)
        SEL_SENSE: sense_q <= reg_wdata;
        SEL_DIR:   dir_q   <= wbyte;
        SEL_IEN:   ien_q   <= wbyte;
        SEL_DOUT:  dout_q  <= wbyte;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/xpin_irq_port.sv
module xpin_irq_port
  import xpin_pkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     reg_sel,
  input  logic           reg_we,
  input  logic [2*N-1:0] reg_wdata,
  output logic [2*N-1:0] reg_rdata,
  input  logic [N-1:0]   pin_in,
  output logic [N-1:0]   pin_out,
  output logic [N-1:0]   pin_oe,
  output logic [N-1:0]   irq
);
  localparam int DW = 2 * N;

  logic [DW-1:0] sense_q;
  logic [N-1:0]  dir_q, ien_q, dout_q, clr_vec;
  logic [N-1:0]  sync_vec, prev_vec, hit_vec, flag_vec;
  logic          sense_we;

  xpin_regs #(.N(N)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .sense_q(sense_q), .dir_q(dir_q), .ien_q(ien_q),
    .dout_q(dout_q), .clr_o(clr_vec), .sense_we_o(sense_we)
  );

  xpin_sync #(.N(N)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .sync_o(sync_vec), .prev_o(prev_vec)
  );

  xpin_flags #(.N(N)) u_flags (
    .clk(clk), .rst_n(rst_n), .sense(sense_q), .sync_i(sync_vec), .prev_i(prev_vec),
    .clr_i(clr_vec), .hit_o(hit_vec), .flag_o(flag_vec)
  );

  assign irq     = flag_vec & ien_q;
  assign pin_oe  = dir_q;
  assign pin_out = dout_q;

  always_comb begin
    case (reg_sel)
      SEL_SENSE: reg_rdata = sense_q;
      SEL_DIR:   reg_rdata = DW'(dir_q);
      SEL_IEN:   reg_rdata = DW'(ien_q);
      SEL_DOUT:  reg_rdata = DW'(dout_q);
      SEL_PINS:  reg_rdata = DW'(sync_vec);
      SEL_FLAG:  reg_rdata = DW'(flag_vec);
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/xpin_irq_port_chk.sv
module xpin_irq_port_chk #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [2*N-1:0] sense,
  input logic [N-1:0]   ien,
  input logic [N-1:0]   pins_rd,
  input logic [N-1:0]   hit,
  input logic [N-1:0]   clr,
  input logic [N-1:0]   flag,
  input logic [N-1:0]   irq,
  input logic           sense_we
);
  // R1: reserved line never flags or requests
  p_line0_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !flag[0] && !irq[0]);

  // R4: no request on a disabled line
  p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq & ~ien) == '0);

  genvar g;
  generate
    for (g = 1; g < N; g++) begin : g_line
      // R6: a set edge flag holds without a clear
      p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sense[2*g +: 2] != 2'b00 && !sense_we && flag[g] && !clr[g]) |=> flag[g]);

      // R8: an edge beats a same-cycle clear
      p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sense[2*g +: 2] != 2'b00 && !sense_we && hit[g]) |=> flag[g]);

      // R5: a clear without an edge empties the flag
      p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sense[2*g +: 2] != 2'b00 && !sense_we && clr[g] && !hit[g]) |=> !flag[g]);

      // R7: level flag mirrors the inverted readback
      p_level_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sense[2*g +: 2] == 2'b00) |-> (flag[g] == ~pins_rd[g]));
    end
  endgenerate
endmodule

bind xpin_irq_port xpin_irq_port_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .sense(sense_q), .ien(ien_q), .pins_rd(sync_vec),
  .hit(hit_vec), .clr(clr_vec), .flag(flag_vec), .irq(irq), .sense_we(sense_we)
);

// File: tb/xpin_irq_port_tb.sv
module xpin_irq_port_tb;
  localparam int N  = 8;
  localparam int DW = 2 * N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    reg_sel = 3'd0;
  logic          reg_we = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [N-1:0]  pins = '1;
  logic [N-1:0]  pin_out, pin_oe, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  xpin_irq_port #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pins),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // Vector: {line[7:5], code[4:3], start[2], final[1], expected flag[0]}
  localparam logic [7:0] VECS [0:9] = '{
    {3'd1, 2'b01, 1'b0, 1'b1, 1'b1},
    {3'd2, 2'b01, 1'b1, 1'b0, 1'b0},
    {3'd3, 2'b10, 1'b1, 1'b0, 1'b1},
    {3'd4, 2'b10, 1'b0, 1'b1, 1'b0},
    {3'd5, 2'b11, 1'b0, 1'b1, 1'b1},
    {3'd6, 2'b11, 1'b1, 1'b0, 1'b1},
    {3'd7, 2'b00, 1'b1, 1'b0, 1'b1},
    {3'd7, 2'b00, 1'b0, 1'b1, 1'b0},
    {3'd2, 2'b11, 1'b1, 1'b1, 1'b0},
    {3'd5, 2'b01, 1'b1, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [DW-1:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [DW-1:0] v);
    reg_sel = s;
    #1;
    v = reg_rdata;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R10 reset state
    for (int s = 0; s < 6; s++) begin
      if (s == 4) continue;
      rd(3'(s), v);
      chk($sformatf("R10 reg %0d after reset", s), v, '0);
    end
    chk("R10 irq/oe/out after reset", {irq, pin_oe}, '0);
    chk("R10 pin_out after reset", DW'(pin_out), '0);

    // R3 direction and output data
    wr(3'd1, 16'h000F);
    wr(3'd3, 16'h0005);
    chk("R3 pin_oe", DW'(pin_oe), 16'h000F);
    chk("R3 pin_out", DW'(pin_out), 16'h0005);
    wr(3'd1, 16'h0000);

    // R2/R4/R7 vector table
    wr(3'd2, 16'h00FE);
    for (int k = 0; k < 10; k++) begin
      logic [2:0] ln;
      logic [1:0] cd;
      logic       st, fn, ex;
      {ln, cd, st, fn, ex} = VECS[k];
      pins = '1;
      pins[ln] = st;
      wr(3'd0, DW'(cd) << (2 * ln));
      settle();
      wr(3'd5, 16'h00FF);
      pins[ln] = fn;
      settle();
      rd(3'd5, v);
      chk($sformatf("R2 R7 vec %0d flag line %0d", k, ln), DW'(v[ln]), DW'(ex));
      chk($sformatf("R4 vec %0d irq line %0d", k, ln), DW'(irq[ln]), DW'(ex));
    end
    pins = '1;
    wr(3'd0, 16'h0000);
    settle();

    // R9 latency of readback and of an edge flag
    @(negedge clk);
    pins = 8'hF7;
    @(posedge clk); @(negedge clk);
    rd(3'd4, v); chk("R9 readback after 1 edge", v, 16'h00FF);
    @(posedge clk); @(negedge clk);
    rd(3'd4, v); chk("R9 readback after 2 edges", v, 16'h00F7);
    pins = '1;
    wr(3'd0, 16'h0100);       // line 4 rising
    settle();
    wr(3'd5, 16'h00FF);
    pins = 8'hEF;
    settle();
    wr(3'd5, 16'h00FF);
    @(negedge clk);
    pins = 8'hFF;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rd(3'd5, v); chk("R9 edge flag after 2 edges", v, 16'h0000);
    @(posedge clk); @(negedge clk);
    rd(3'd5, v); chk("R9 edge flag after 3 edges", v, 16'h0010);

    // R4/R6/R5 on line 1 rising with enable off
    wr(3'd2, 16'h0000);
    pins = 8'hFD;
    wr(3'd0, 16'h0004);
    settle();
    wr(3'd5, 16'h00FF);
    pins = 8'hFF;
    settle();
    rd(3'd5, v); chk("R4 flag recorded while disabled", v, 16'h0002);
    chk("R4 no irq while disabled", DW'(irq), '0);
    pins = 8'hFD;
    settle();
    rd(3'd5, v); chk("R6 flag sticky after pin returns", v, 16'h0002);
    wr(3'd2, 16'h0002);
    chk("R4 irq after enable", DW'(irq), 16'h0002);
    wr(3'd5, 16'h00FD);
    rd(3'd5, v); chk("R5 zero bit keeps flag", v, 16'h0002);
    wr(3'd5, 16'h0002);
    rd(3'd5, v); chk("R5 one bit clears flag", v, 16'h0000);
    chk("R5 irq drops after clear", DW'(irq), '0);

    // R8 set wins over clear (line 1 rising, pin now low)
    @(negedge clk);
    pins = 8'hFF;
    @(posedge clk); @(posedge clk); @(negedge clk);
    reg_sel = 3'd5; reg_wdata = 16'h0002; reg_we = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
    rd(3'd5, v); chk("R8 set beats clear", v, 16'h0002);

    // R7 clearing a level-mode line is harmless
    wr(3'd0, 16'h0000);
    pins = 8'hBF;
    settle();
    wr(3'd5, 16'h00FF);
    rd(3'd5, v); chk("R7 level flag survives clear write", v, 16'h0040);
    pins = 8'hFF;
    settle();
    rd(3'd5, v); chk("R7 level flag follows pin", v, 16'h0000);

    // R1 reserved line 0, both edges, enabled
    wr(3'd2, 16'h00FF);
    wr(3'd0, 16'h0003);
    pins = 8'hFE;
    settle();
    pins = 8'hFF;
    settle();
    rd(3'd5, v); chk("R1 line 0 flag", v, 16'h0000);
    chk("R1 line 0 irq", DW'(irq), '0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule